// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a countdown timer behind a single memory-mapped register on a pipelined bus slave port. Software writes one word: the top bit picks the behaviour at expiry and the other bits give the start value. For each clock in which the count-enable input is high, the count drops by one. When it reaches zero the block emits a one-clock expiry pulse. In one-shot mode it then stays at zero. In reload mode it loads the programmed value again and keeps counting.

The expiry output can drive a processor interrupt line. It can also be wired to a system reset, so the block serves as a watchdog that software must keep rewriting. The count-enable input is meant to be pulled low while the processor is halted for debug, which freezes the count. A read returns the live count with the mode bit on top.

Top module: `intv_timer`

## Requirements
- R1: After reset the count is 0, the mode is one-shot, and `tick_expire` and `bus_ack` are low. A read then returns 0.
- R2: A write (`bus_cyc`, `bus_stb` and `bus_we` high) loads the count and the reload value from `bus_wdata[DATA_W-2:0]`. It loads the mode from `bus_wdata[DATA_W-1]`, where 1 means reload and 0 means one-shot. A read returns `{mode, count}` with the mode in bit DATA_W-1.
- R3: Each cycle with `bus_cyc` and `bus_stb` high is answered by `bus_ack` high in the next cycle only. `bus_stall` is always 0. `bus_rdata` in the ack cycle holds the register value from the request cycle.
- R4: The count drops by exactly one on each clock with `cnt_en` high and a nonzero count. It holds its value while `cnt_en` is low.
- R5: In one-shot mode with start value N, exactly one expiry pulse follows the N-th enabled clock. The count then stays at 0.
- R6: In reload mode with value N, a pulse follows every N-th enabled clock and the count restarts from N. With N = 1 the pulse repeats on every enabled clock.
- R7: `tick_expire` is a registered output. It is high only in the cycle after an enabled clock edge at which the count was 1.
- R8: Writing a value field of 0 stops the timer without any expiry pulse, in either mode.
- R9: A write in the same cycle as an enabled count step takes priority. The count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, low while the processor is halted |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data: mode bit on top, start value below |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| bus_stall | output | 1 | Stall, tied low |
| bus_rdata | output | DATA_W | Read data `{mode, count}` |
| tick_expire | output | 1 | One-clock expiry pulse, to an interrupt or a reset |

## Verification
The bench sweeps start values 1 through 10 in both modes while holding `cnt_en` high. In one-shot mode it checks that the first pulse lands on edge N, that only one pulse occurs, and that the count reads back 0. In reload mode it checks that pulses land on every multiple of N and that the remaining count matches the arithmetic residue; this distinguishes a reload from a stop or an off-by-one reload. Separate patterns hold `cnt_en` low to show the count freezing, write zero to show a silent stop, and write during an enabled step to show that the write takes priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RELOAD  = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          ld_valid,
    input  tmr_mode_e     ld_mode,
    input  logic [CW-1:0] ld_value,
    output logic [CW-1:0] count,
    output tmr_mode_e     mode,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] reload;
        tmr_mode_e     mode;
        logic          expire;
    } cnt_state_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (ld_valid) begin
            st_d.cnt    = ld_value;
            st_d.reload = ld_value;
            st_d.mode   = ld_mode;
        end else if (cnt_en && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE) begin
                st_d.expire = 1'b1;
                st_d.cnt    = (st_q.mode == MODE_RELOAD) ? st_q.reload : '0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, reload: '0, mode: MODE_ONESHOT, expire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign mode   = st_q.mode;
    assign expire = st_q.expire;
endmodule

// File: rtl/tmr_port.sv
module tmr_port
    import tmr_pkg::*;
#(
    parameter int DW = 32,
    localparam int CW = DW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc,
    input  logic          stb,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  tmr_mode_e     cur_mode,
    input  logic [CW-1:0] cur_count,
    output logic          ld_valid,
    output tmr_mode_e     ld_mode,
    output logic [CW-1:0] ld_value,
    output logic          ack,
    output logic          stall,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          ack;
        logic [DW-1:0] rdata;
    } port_state_t;

    port_state_t pt_d, pt_q;
    logic        req;

    assign req      = cyc && stb;
    assign ld_valid = req && we;
    assign ld_mode  = tmr_mode_e'(wdata[DW-1]);
    assign ld_value = wdata[CW-1:0];

    always_comb begin
        pt_d     = pt_q;
        pt_d.ack = req;
        if (req) begin
            pt_d.rdata = {cur_mode, cur_count};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_q <= '{ack: 1'b0, rdata: '0};
        end else begin
            pt_q <= pt_d;
        end
    end

    assign ack   = pt_q.ack;
    assign rdata = pt_q.rdata;
    assign stall = 1'b0;
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_expire
);
    localparam int CW = DATA_W - 1;

    logic          ld_valid;
    tmr_mode_e     ld_mode;
    logic [CW-1:0] ld_value;
    logic [CW-1:0] cur_count;
    tmr_mode_e     cur_mode;

    tmr_port #(.DW(DATA_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .cyc       (bus_cyc),
        .stb       (bus_stb),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .cur_mode  (cur_mode),
        .cur_count (cur_count),
        .ld_valid  (ld_valid),
        .ld_mode   (ld_mode),
        .ld_value  (ld_value),
        .ack       (bus_ack),
        .stall     (bus_stall),
        .rdata     (bus_rdata)
    );

    tmr_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .ld_valid (ld_valid),
        .ld_mode  (ld_mode),
        .ld_value (ld_value),
        .count    (cur_count),
        .mode     (cur_mode),
        .expire   (tick_expire)
    );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              bus_stall,
    input logic              tick_expire,
    input logic [DATA_W-2:0] cur_count
);
    // R3
    ack_next_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_stb) |=> bus_ack);

    // R3
    no_spur_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_cyc && bus_stb) |=> !bus_ack);

    // R3
    always_comb begin
        stall_low_chk: assert (bus_stall == 1'b0);
    end

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !(bus_cyc && bus_stb && bus_we)) |=> $stable(cur_count));

    // R7
    expire_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tick_expire |-> ($past(cnt_en) && ($past(cur_count) == 1)
                         && !$past(bus_cyc && bus_stb && bus_we)));

    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_stb && bus_we && (bus_wdata[DATA_W-2:0] == '0))
        |=> (!tick_expire && (cur_count == '0)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_stb && bus_we)
        |=> (cur_count == $past(bus_wdata[DATA_W-2:0])));
endmodule

bind intv_timer intv_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .bus_cyc     (bus_cyc),
    .bus_stb     (bus_stb),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .bus_stall   (bus_stall),
    .tick_expire (tick_expire),
    .cur_count   (cur_count)
);

// File: tb/tb_intv_timer.sv
module tb_intv_timer;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_en = 1'b0;
    logic          bus_cyc = 1'b0;
    logic          bus_stb = 1'b0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ack;
    logic          bus_stall;
    logic [DW-1:0] bus_rdata;
    logic          tick_expire;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    intv_timer #(.DATA_W(DW)) dut (
        .clk         (clk),
        .rst         (rst),
        .cnt_en      (cnt_en),
        .bus_cyc     (bus_cyc),
        .bus_stb     (bus_stb),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_ack     (bus_ack),
        .bus_stall   (bus_stall),
        .bus_rdata   (bus_rdata),
        .tick_expire (tick_expire)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input logic m, input int v);
        return {m, (DW-1)'(v)};
    endfunction

    // R3: ack one cycle after request, no stall
    task automatic do_write(input logic [DW-1:0] v);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_wdata = v;
        @(negedge clk);
        check("R3 write ack", bus_ack, 1);
        check("R3 stall", bus_stall, 0);
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
    endtask

    task automatic do_read(output logic [DW-1:0] d);
        bus_cyc = 1; bus_stb = 1; bus_we = 0;
        @(negedge clk);
        check("R3 read ack", bus_ack, 1);
        d = bus_rdata;
        bus_cyc = 0; bus_stb = 0;
        @(negedge clk);
        check("R3 ack drops", bus_ack, 0);
    endtask

    // Run k enabled edges; report first pulse edge, pulse count, pulses off grid
    task automatic run_en(input int k, input int period, output int first,
                          output int pulses, output int offgrid);
        first = 0; pulses = 0; offgrid = 0;
        cnt_en = 1;
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            if (tick_expire) begin
                if (first == 0) first = i;
                pulses++;
                if (period != 0 && (i % period) != 0) offgrid++;
            end
        end
        cnt_en = 0;
    endtask

    initial begin
        logic [DW-1:0] d;
        int f, p, o, m, res;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 expire at reset", tick_expire, 0);
        check("R1 ack at reset", bus_ack, 0);
        do_read(d);
        check("R1 reset read", d, 0);

        // R5: one-shot sweep
        for (int n = 1; n <= 10; n++) begin
            do_write(word(1'b0, n));
            do_read(d);
            check("R2 readback one-shot", d, word(1'b0, n));
            run_en(n + 3, 0, f, p, o);
            check("R5 first pulse edge", f, n);
            check("R5 single pulse", p, 1);
            do_read(d);
            check("R5 stays zero", d, word(1'b0, 0));
        end

        // R6: reload sweep
        for (int n = 1; n <= 10; n++) begin
            do_write(word(1'b1, n));
            m = 3 * n + 2;
            run_en(m, n, f, p, o);
            check("R6 first pulse edge", f, n);
            check("R6 pulse count", p, m / n);
            check("R6 pulse spacing", o, 0);
            res = ((m % n) == 0) ? n : n - (m % n);
            do_read(d);
            check("R6 residual count", d, word(1'b1, res));
        end

        // R4: decrement and freeze
        do_write(word(1'b0, 20));
        run_en(5, 0, f, p, o);
        do_read(d);
        check("R4 decrement", d, word(1'b0, 15));
        repeat (10) @(negedge clk);
        check("R4 no pulse while off", tick_expire, 0);
        do_read(d);
        check("R4 frozen", d, word(1'b0, 15));

        // R7: pulse width one cycle in one-shot
        do_write(word(1'b0, 2));
        cnt_en = 1;
        @(negedge clk);
        @(negedge clk);
        check("R7 pulse high", tick_expire, 1);
        @(negedge clk);
        check("R7 pulse one cycle", tick_expire, 0);
        cnt_en = 0;

        // R8: zero write stops silently
        do_write(word(1'b1, 5));
        run_en(2, 0, f, p, o);
        do_write(word(1'b1, 0));
        run_en(10, 0, f, p, o);
        check("R8 no pulse", p, 0);
        do_read(d);
        check("R8 stopped", d, word(1'b1, 0));

        // R9: write during an enabled step
        do_write(word(1'b0, 30));
        cnt_en = 1;
        @(negedge clk);
        do_write(word(1'b1, 7));
        cnt_en = 0;
        do_read(d);
        check("R9 write wins", d, word(1'b1, 7));

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule